// File: doc/BRIEF.md
# Serial Link Power-Up and Reset Sequencer

This block brings a serial-link controller and its PHY out of reset in a fixed order, and puts them back into a safe reset state on request. A start command first runs the reset-entry steps and then the release steps. A shutdown command runs only the reset-entry steps, so that firmware on a later boot finds the link down.

Before it asserts any reset, the block checks whether earlier boot firmware left a link running. It reads two status inputs for this: the reference clock was left enabled, and the link-training engine was left enabled. When both are high, the block pulses a command that forces the link state machine back to its detect state, and only then does it stop training.

During release, the block waits a short interval between PHY power-up and reference-clock enable. This gives the PHY's internal reset synchronizer enough clock edges. It also waits for the clocks to settle before it touches any reset. Every wait is a parameter counted in clock cycles.

Top module: `lnk_pwrseq`

## Requirements
- R1: After reset, the outputs are: PHY powerdown 1, reference clock 0, training enable 0, controller reset 1, endpoint reset inactive, force-detect 0, busy 0, done 0.
- R2: A command accepted while `refclk_on_i` and `train_on_i` are both 1 pulses `force_detect_o` for exactly one cycle, on the first cycle after acceptance. Training is dropped and the controller reset is asserted on the following cycle. If either status input is 0, there is no pulse and those steps happen on the first cycle.
- R3: One cycle after training is dropped, PHY powerdown goes to 1 and the reference clock goes to 0, for both commands.
- R4: On a start, PHY powerdown clears on the next cycle. The reference clock enables exactly PHYUP_CYC cycles later.
- R5: The endpoint reset becomes active exactly CLKSET_CYC cycles after the reference clock enables. It stays active for exactly EPRST_CYC cycles.
- R6: `ep_pol_i` sets the active level of the endpoint reset pin. With 1 the pin is high while active. With 0 the pin is low while active, and high at all other times.
- R7: The controller reset is released one cycle after the endpoint reset goes inactive. RELSET_CYC cycles after that, `done_o` and `train_en_o` rise together.
- R8: A shutdown ends in idle with PHY powerdown 1, reference clock 0, training 0, controller reset 1 and done 0. The block is busy for exactly two cycles, or three cycles when the force-detect pulse is issued.
- R9: When start and shutdown arrive in the same cycle, the shutdown sequence runs.
- R10: `busy_o` is high from the cycle after acceptance until the sequence ends, and it is never high together with `done_o`. Commands that arrive while busy have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a full reset-and-release sequence |
| shutdown_i | input | 1 | Request reset entry only; wins over start |
| refclk_on_i | input | 1 | Status: reference clock currently enabled |
| train_on_i | input | 1 | Status: link training currently enabled |
| ep_pol_i | input | 1 | Endpoint reset active level (1 = active high) |
| phy_pd_o | output | 1 | PHY test powerdown |
| refclk_en_o | output | 1 | Reference clock enable |
| train_en_o | output | 1 | Link-training enable |
| ctl_rst_o | output | 1 | Controller software reset, active high |
| ep_rst_o | output | 1 | External endpoint reset pin |
| force_detect_o | output | 1 | One-cycle command forcing link state to detect |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Release sequence completed |

## Verification
A wrong state or a mis-loaded wait changes the cycle on which an enable or a reset edge appears at the ports. Every output is compared against an independent timeline on every cycle of each sequence, so an error shows on the first cycle it occurs. Two other faults appear at the next transition: a missed detection of a running link, and a shutdown that falls through into the release steps. The first shows as an absent `force_detect_o` pulse. The second shows as `phy_pd_o` clearing two cycles after acceptance.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FORCE,
        ST_DROP,
        ST_PWRDN,
        ST_PHYUP,
        ST_CLKSET,
        ST_EPON,
        ST_EPOFF,
        ST_RELSET,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    shut;
        logic    force_det;
        logic    train;
        logic    swrst;
        logic    pd;
        logic    refclk;
        logic    ep_act;
        logic    done;
    } seq_regs_t;

endpackage

// File: rtl/lps_timer.sv
module lps_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lps_ep_pin.sv
module lps_ep_pin (
    input  logic act_i,
    input  logic pol_i,
    output logic pin_o
);
    // Active level follows pol_i; inactive level is its complement.
    assign pin_o = pol_i ? act_i : ~act_i;
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
#(
    parameter int W          = 8,
    parameter int PHYUP_CYC  = 4,
    parameter int CLKSET_CYC = 4,
    parameter int EPRST_CYC  = 4,
    parameter int RELSET_CYC = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         shutdown_i,
    input  logic         refclk_on_i,
    input  logic         train_on_i,
    input  logic         tmr_zero_i,
    output logic         tmr_load_o,
    output logic [W-1:0] tmr_val_o,
    output seq_regs_t    regs_o
);
    localparam logic [W-1:0] PHYUP_LD  = W'(PHYUP_CYC - 1);
    localparam logic [W-1:0] CLKSET_LD = W'(CLKSET_CYC - 1);
    localparam logic [W-1:0] EPRST_LD  = W'(EPRST_CYC - 1);
    localparam logic [W-1:0] RELSET_LD = W'(RELSET_CYC - 1);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d           = seq_q;
        seq_d.force_det = 1'b0;
        tmr_load_o      = 1'b0;
        tmr_val_o       = '0;
        unique case (seq_q.st)
            ST_IDLE, ST_DONE: begin
                if (shutdown_i || start_i) begin
                    seq_d.shut = shutdown_i;
                    seq_d.done = 1'b0;
                    if (refclk_on_i && train_on_i) begin
                        seq_d.st        = ST_FORCE;
                        seq_d.force_det = 1'b1;
                    end else begin
                        seq_d.st    = ST_DROP;
                        seq_d.train = 1'b0;
                        seq_d.swrst = 1'b1;
                    end
                end
            end
            ST_FORCE: begin
                seq_d.st    = ST_DROP;
                seq_d.train = 1'b0;
                seq_d.swrst = 1'b1;
            end
            ST_DROP: begin
                seq_d.st     = ST_PWRDN;
                seq_d.pd     = 1'b1;
                seq_d.refclk = 1'b0;
            end
            ST_PWRDN: begin
                if (seq_q.shut) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.st   = ST_PHYUP;
                    seq_d.pd   = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PHYUP_LD;
                end
            end
            ST_PHYUP: begin
                if (tmr_zero_i) begin
                    seq_d.st     = ST_CLKSET;
                    seq_d.refclk = 1'b1;
                    tmr_load_o   = 1'b1;
                    tmr_val_o    = CLKSET_LD;
                end
            end
            ST_CLKSET: begin
                if (tmr_zero_i) begin
                    seq_d.st     = ST_EPON;
                    seq_d.ep_act = 1'b1;
                    tmr_load_o   = 1'b1;
                    tmr_val_o    = EPRST_LD;
                end
            end
            ST_EPON: begin
                if (tmr_zero_i) begin
                    seq_d.st     = ST_EPOFF;
                    seq_d.ep_act = 1'b0;
                end
            end
            ST_EPOFF: begin
                seq_d.st    = ST_RELSET;
                seq_d.swrst = 1'b0;
                tmr_load_o  = 1'b1;
                tmr_val_o   = RELSET_LD;
            end
            ST_RELSET: begin
                if (tmr_zero_i) begin
                    seq_d.st    = ST_DONE;
                    seq_d.done  = 1'b1;
                    seq_d.train = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: ST_IDLE, shut: 1'b0, force_det: 1'b0, train: 1'b0,
                       swrst: 1'b1, pd: 1'b1, refclk: 1'b0, ep_act: 1'b0,
                       done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign regs_o = seq_q;
endmodule

// File: rtl/lnk_pwrseq.sv
module lnk_pwrseq
    import lps_pkg::*;
#(
    parameter int PHYUP_CYC  = 1000,
    parameter int CLKSET_CYC = 30000,
    parameter int EPRST_CYC  = 10000,
    parameter int RELSET_CYC = 30000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic shutdown_i,
    input  logic refclk_on_i,
    input  logic train_on_i,
    input  logic ep_pol_i,
    output logic phy_pd_o,
    output logic refclk_en_o,
    output logic train_en_o,
    output logic ctl_rst_o,
    output logic ep_rst_o,
    output logic force_detect_o,
    output logic busy_o,
    output logic done_o
);
    localparam int MAX_A = (PHYUP_CYC > CLKSET_CYC) ? PHYUP_CYC : CLKSET_CYC;
    localparam int MAX_B = (EPRST_CYC > RELSET_CYC) ? EPRST_CYC : RELSET_CYC;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAX_D + 1);

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    seq_regs_t     regs;

    lps_fsm #(
        .W(TW), .PHYUP_CYC(PHYUP_CYC), .CLKSET_CYC(CLKSET_CYC),
        .EPRST_CYC(EPRST_CYC), .RELSET_CYC(RELSET_CYC)
    ) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .shutdown_i(shutdown_i), .refclk_on_i(refclk_on_i),
        .train_on_i(train_on_i), .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .regs_o(regs)
    );

    lps_timer #(.W(TW)) u_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
        .val_i(tmr_val), .zero_o(tmr_zero)
    );

    lps_ep_pin u_pin (
        .act_i(regs.ep_act), .pol_i(ep_pol_i), .pin_o(ep_rst_o)
    );

    assign phy_pd_o       = regs.pd;
    assign refclk_en_o    = regs.refclk;
    assign train_en_o     = regs.train;
    assign ctl_rst_o      = regs.swrst;
    assign force_detect_o = regs.force_det;
    assign done_o         = regs.done;
    assign busy_o         = (regs.st != ST_IDLE) && (regs.st != ST_DONE);
endmodule

// File: rtl/lps_chk.sv
module lps_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic refclk_on_i,
    input logic train_on_i,
    input logic ep_pol_i,
    input logic phy_pd_o,
    input logic refclk_en_o,
    input logic train_en_o,
    input logic ctl_rst_o,
    input logic ep_rst_o,
    input logic force_detect_o,
    input logic busy_o,
    input logic done_o
);
    // R2: pulse only when both status bits were high
    a_r2_force_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(force_detect_o) |-> $past(refclk_on_i && train_on_i));
    // R2: pulse lasts one cycle
    a_r2_force_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_detect_o |=> !force_detect_o);
    // R3: powerdown never coexists with a running reference clock
    a_r3_pd_no_refclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phy_pd_o |-> !refclk_en_o);
    // R4: reference clock only enables with PHY powered
    a_r4_refclk_after_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(refclk_en_o) |-> !phy_pd_o);
    // R7: controller reset released only with endpoint reset inactive
    a_r7_swrst_after_ep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ctl_rst_o) |-> (ep_rst_o != ep_pol_i));
    // R7: done implies fully released state
    a_r7_done_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!ctl_rst_o && refclk_en_o && !phy_pd_o && train_en_o));
    // R10: busy and done exclusive
    a_r10_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));
endmodule

bind lnk_pwrseq lps_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .refclk_on_i(refclk_on_i),
    .train_on_i(train_on_i), .ep_pol_i(ep_pol_i), .phy_pd_o(phy_pd_o),
    .refclk_en_o(refclk_en_o), .train_en_o(train_en_o), .ctl_rst_o(ctl_rst_o),
    .ep_rst_o(ep_rst_o), .force_detect_o(force_detect_o), .busy_o(busy_o),
    .done_o(done_o)
);

// File: tb/lnk_pwrseq_bench.sv
module lnk_pwrseq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P = 3, C = 5, E = 4, R = 6;
    localparam int T_SWREL = 3 + P + C + E;
    localparam int T_DONE  = T_SWREL + R;

    // fields: [6] refclk_on [5] train_on [4] pol [3] start [2] shutdown
    //         [1:0] inject at k=5 (0 none, 1 start, 2 shutdown)
    localparam int NV = 8;
    localparam logic [6:0] TBL [NV] = '{
        7'b0011000, 7'b1111001, 7'b1001010, 7'b0101000,
        7'b1100100, 7'b1111100, 7'b0001000, 7'b1111000
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, shut = 1'b0, rc_on = 1'b0, tr_on = 1'b0, pol = 1'b1;
    logic pd, rce, tre, crst, epr, fdet, busy, done;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_pwrseq #(.PHYUP_CYC(P), .CLKSET_CYC(C), .EPRST_CYC(E), .RELSET_CYC(R))
    u_lnk_pwrseq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shutdown_i(shut),
        .refclk_on_i(rc_on), .train_on_i(tr_on), .ep_pol_i(pol),
        .phy_pd_o(pd), .refclk_en_o(rce), .train_en_o(tre), .ctl_rst_o(crst),
        .ep_rst_o(epr), .force_detect_o(fdet), .busy_o(busy), .done_o(done)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_seq(input logic [6:0] v);
        logic d, sh, pl;
        int off, tend, t;
        d   = v[6] & v[5];
        sh  = v[2];
        pl  = v[4];
        off = d ? 1 : 0;
        tend = sh ? 2 : T_DONE;
        rc_on = v[6]; tr_on = v[5]; pol = pl; start = v[3]; shut = v[2];
        @(posedge clk); @(negedge clk);
        start = 1'b0; shut = 1'b0;
        for (int k = 0; k <= off + tend + 1; k++) begin
            t = k - off;
            chk("R2 force_detect", fdet, d && k == 0);
            chk("R10 busy", busy, t < tend);
            chk("R7 done", done, !sh && t >= tend);
            if (t >= 0) begin
                chk("R2 train_en", tre, !sh && t >= T_DONE);
                chk("R7 ctl_rst", crst, sh ? 1'b1 : (t < T_SWREL));
                chk("R5 R6 ep_rst pin", epr,
                    pl ~^ (!sh && t >= 2+P+C && t < 2+P+C+E));
            end
            if (t >= 1) begin
                chk(sh ? "R8 phy_pd" : "R4 phy_pd", pd, sh ? 1'b1 : (t == 1));
                chk("R4 refclk_en", rce, !sh && t >= 2+P);
            end
            if (k == 5 && v[1:0] != 2'd0) begin
                start = (v[1:0] == 2'd1);   // R10: ignored while busy
                shut  = (v[1:0] == 2'd2);
            end
            @(posedge clk); @(negedge clk);
            start = 1'b0; shut = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 phy_pd", pd, 1'b1);
        chk("R1 refclk_en", rce, 1'b0);
        chk("R1 train_en", tre, 1'b0);
        chk("R1 ctl_rst", crst, 1'b1);
        chk("R1 ep_rst", epr, 1'b0);
        chk("R1 force", fdet, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_seq(TBL[i]);
        // R9: both commands -> shutdown path observable as pd held high at t=2
        rc_on = 1'b0; tr_on = 1'b0; start = 1'b1; shut = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0; shut = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R9 phy_pd held", pd, 1'b1);
        chk("R9 busy ended", busy, 1'b0);
        chk("R9 done low", done, 1'b0);
        // R6: low-active pin idles high
        pol = 1'b0;
        @(negedge clk);
        chk("R6 idle pin level", epr, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule